// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a single-cycle processor core. It drives the current PC out as the instruction memory address, along with the PC plus four. On every rising clock edge it loads a new PC. The new PC comes from one of three places: the next sequential word, a PC-relative branch target, or a pseudo-direct jump target.

The decode and execute logic supply the branch and jump controls, the ALU zero flag, the 16-bit immediate and the 26-bit jump field. The block adds no pipeline stage. The PC that results from an instruction is visible one clock edge after that instruction is presented.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0. Reset wins over every other input, including a jump.
- R2: `pc_plus4_o` always equals `pc_o` + 4, taken modulo 2^32.
- R3: When neither branch nor jump is asserted, the next PC is PC + 4.
- R4: When branch is asserted and the zero flag is 1, the next PC is PC + 4 + (immediate sign-extended from bit 15, multiplied by 4). This holds for both positive and negative offsets.
- R5: When branch is asserted and the zero flag is 0, the next PC is PC + 4.
- R6: A zero flag of 1 without the branch control has no effect, and the next PC is PC + 4.
- R7: When jump is asserted, the next PC is formed from three fields. Bits 31:28 hold the upper nibble, bits 27:2 hold the 26-bit jump field, and bits 1:0 are zero.
- R8: When jump and a taken branch are requested together, the jump target is used.
- R9: The upper nibble of a jump target is taken from PC + 4, not from the current PC. The two differ when PC + 4 crosses a 256 MB boundary.
- R10: The sequential path wraps from 0xFFFFFFFC to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imm_field | input | 16 | Branch word offset from the current instruction |
| jump_field | input | 26 | Jump word address from the current instruction |
| br_en | input | 1 | Branch-on-equal control |
| jmp_en | input | 1 | Jump control |
| alu_zero | input | 1 | ALU zero flag |
| pc_o | output | 32 | Current PC, used as the instruction memory address |
| pc_plus4_o | output | 32 | Current PC plus 4 |

## Verification
The bench drives a negative branch offset from PC 0. A design that zero-extends the immediate would land far ahead of the PC instead of at 0xFFFFFFFC, and the same run then checks the wrap back to zero. Two jumps are made where PC and PC + 4 lie on opposite sides of a 256 MB boundary. A design that takes the upper nibble from the current PC would land one region off. Two further cases cover a jump asserted together with a taken branch, and the zero flag raised without the branch control. A design with the wrong priority, or with a missing branch gate, would follow the branch target there.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W  = 32,
  parameter int IMM_W = 16,
  parameter int JF_W  = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IMM_W-1:0] imm_field,
  input  logic [JF_W-1:0]  jump_field,
  input  logic             br_en,
  input  logic             jmp_en,
  input  logic             alu_zero,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  pc_plus4_o
);
  localparam int HI_W  = PC_W - JF_W - 2;
  localparam int EXT_W = PC_W - IMM_W - 2;

  logic [PC_W-1:0] pc_q, br_tgt, jmp_tgt, pc_next;
  logic            take_br;

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_q + PC_W'(4);
  assign take_br    = br_en & alu_zero;
  assign br_tgt     = pc_plus4_o + {{EXT_W{imm_field[IMM_W-1]}}, imm_field, 2'b00};
  assign jmp_tgt    = {pc_plus4_o[PC_W-1 -: HI_W], jump_field, 2'b00};

  always_comb begin
    if (jmp_en)       pc_next = jmp_tgt;
    else if (take_br) pc_next = br_tgt;
    else              pc_next = pc_plus4_o;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> pc_o == '0);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!br_en && !jmp_en) |=> pc_o == $past(pc_o) + PC_W'(4));

  assert_branch_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (br_en && alu_zero && !jmp_en) |=>
      pc_o == $past(pc_o) + PC_W'(4)
              + {{EXT_W{$past(imm_field[IMM_W-1])}}, $past(imm_field), 2'b00});

  assert_branch_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (!alu_zero && !jmp_en) |=> pc_o == $past(pc_o) + PC_W'(4));

  assert_jump_fields_R7: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> pc_o[1:0] == 2'b00 && pc_o[JF_W+1:2] == $past(jump_field));

  assert_jump_upper_R9: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> pc_o[PC_W-1 -: HI_W] == $past(pc_plus4_o[PC_W-1 -: HI_W]));

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_o[1:0] == 2'b00);
endmodule

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imm_field = '0;
  logic [25:0] jump_field = '0;
  logic        br_en = 1'b0, jmp_en = 1'b0, alu_zero = 1'b0;
  logic [31:0] pc_o, pc_plus4_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .imm_field(imm_field), .jump_field(jump_field),
    .br_en(br_en), .jmp_en(jmp_en), .alu_zero(alu_zero),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit r, bit br, bit jp, bit z, logic [15:0] imm, logic [25:0] jf);
    @(negedge clk);
    rst = r; br_en = br; jmp_en = jp; alu_zero = z; imm_field = imm; jump_field = jf;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    step(1, 0, 0, 0, '0, '0);
    step(1, 0, 0, 0, '0, '0);
    check("R1 reset pc", pc_o, 32'h0);
    check("R2 plus4 at reset", pc_plus4_o, 32'h4);
  endtask

  task automatic t_sequential();
    step(0, 0, 0, 0, 16'h1234, 26'h155);
    check("R3 seq 1", pc_o, 32'h4);
    step(0, 0, 0, 0, 16'hFFFF, '0);
    check("R3 seq 2", pc_o, 32'h8);
    check("R2 plus4", pc_plus4_o, 32'hC);
  endtask

  task automatic t_zero_only();
    step(0, 0, 0, 1, 16'h0040, '0);
    check("R6 zero without branch", pc_o, 32'hC);
  endtask

  task automatic t_branch_not_taken();
    step(0, 1, 0, 0, 16'h0064, '0);
    check("R5 branch not taken", pc_o, 32'h10);
  endtask

  task automatic t_branch_taken();
    step(0, 1, 0, 1, 16'h0003, '0);
    check("R4 branch forward", pc_o, 32'h20);
    step(0, 1, 0, 1, 16'hFFFB, '0);
    check("R4 branch backward", pc_o, 32'h10);
  endtask

  task automatic t_jump();
    step(0, 0, 1, 0, '0, 26'h0000040);
    check("R7 jump", pc_o, 32'h100);
    step(0, 1, 1, 1, 16'h0007, 26'h0000010);
    check("R8 jump over branch", pc_o, 32'h40);
  endtask

  task automatic t_upper_nibble();
    step(0, 0, 1, 0, '0, 26'h3FFFFFF);
    check("R7 jump max field", pc_o, 32'h0FFFFFFC);
    step(0, 0, 1, 0, '0, 26'h0000001);
    check("R9 upper from pc+4", pc_o, 32'h10000004);
  endtask

  task automatic t_reset_over_jump();
    step(1, 1, 1, 1, 16'h0005, 26'h0000123);
    check("R1 reset over jump", pc_o, 32'h0);
  endtask

  task automatic t_wrap();
    step(0, 1, 0, 1, 16'hFFFE, '0);
    check("R4 negative to top", pc_o, 32'hFFFFFFFC);
    check("R10 plus4 wraps", pc_plus4_o, 32'h0);
    step(0, 0, 0, 0, '0, '0);
    check("R10 seq wraps", pc_o, 32'h0);
    step(0, 1, 0, 1, 16'hFFFE, '0);
    step(0, 0, 1, 0, '0, 26'h0000002);
    check("R9 upper after wrap", pc_o, 32'h00000008);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_zero_only();
    t_branch_not_taken();
    t_branch_taken();
    t_jump();
    t_upper_nibble();
    t_reset_over_jump();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule